// File: doc/BRIEF.md
# In-Order Multi-Issue Window with Hazard Check

This block is the issue stage of a superscalar pipeline. It holds up to `W` decoded instructions, each naming one destination and two source registers, kept in program order with slot 0 the oldest. Every cycle it compares each window entry with the older entries ahead of it and with a scoreboard of registers whose results are still outstanding. It then issues the longest run of hazard-free instructions that starts at the oldest slot. An instruction that is blocked holds back every younger one.

Read-after-write conflicts are true dependencies. Write-after-write and write-after-read conflicts are false dependencies, but they block in the same way because the stage does no register renaming. Issuing an instruction marks its destination as pending. A writeback pulse clears the pending mark. The window can be refilled in two ways, chosen by an input. In fixed mode, a new batch enters only when the whole current batch issues. In gliding mode, the entries that remain move down to the lowest slots and every freed slot is refilled in the same cycle. A flush input empties the window and clears the scoreboard.

Top module: `issue_window`

## Requirements
- R1: After reset the window is empty, `issValid` is 0 and no register is pending. The first instruction accepted therefore issues in the cycle after it is taken.
- R2: `issValid` is always a run of ones that starts at bit 0. Slot i issues only if every older valid slot issues in the same cycle.
- R3: An entry whose source equals the destination of an older window entry does not issue (read after write).
- R4: An entry whose destination equals the destination or a source of an older window entry does not issue (write after write, write after read).
- R5: An entry does not issue while any of its three registers is pending. A register becomes pending at the clock edge where an instruction writing it issues. A register stops being pending at the edge where `wbValid` is high with `wbReg` naming it, so a blocked entry can issue in the following cycle.
- R6: In fixed mode (`glideMode`=0), `inTake` is 0 unless every valid window entry issues in that cycle. When they all do, `inTake` is the smaller of `W` and the number offered.
- R7: In gliding mode (`glideMode`=1), `inTake` is the smaller of the offered count and the number of slots not held by unissued entries. Accepted instructions go in behind the remaining entries, in order.
- R8: While `flush` is high, `issValid` and `inTake` are 0. From the next cycle the window is empty and every register is free.
- R9: For each issued slot i, `issDst` field i (bits i*RW upward) carries that entry's destination. Slot order is program order.
- R10: The issue width `W` must lie between 2 and 6.
- R11: The offered count is the number of consecutive ones in `inValid` starting at bit 0. Input slot k (field k of `inDst`/`inSrcA`/`inSrcB`) is the k-th oldest offered instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the window and clear the scoreboard |
| glideMode | input | 1 | 1 = gliding refill, 0 = fixed batch |
| inValid | input | W | Offered instructions, contiguous from bit 0 |
| inDst | input | W*RW | Destination register of each offered instruction |
| inSrcA | input | W*RW | First source register of each offered instruction |
| inSrcB | input | W*RW | Second source register of each offered instruction |
| inTake | output | 3 | Number of offered instructions accepted at this edge |
| wbValid | input | 1 | A result is written back this cycle |
| wbReg | input | RW | Register whose result is written back |
| issValid | output | W | Slots issuing this cycle |
| issDst | output | W*RW | Destination register of each issuing slot |

## Verification
If a scoreboard bit stays set after its writeback, the affected entry never appears in `issValid` again, and every younger entry stalls with it. If a bit fails to set, a dependent entry issues one cycle too early. Either error shows at the ports within one cycle of the wrong edge. A miscounted window or a wrong shift shows up as an `inTake` value that no longer matches the free slot count, or as the wrong `issDst` on the next issue. The bench tracks the queue the producer drains and the registers outstanding, so a single lost, duplicated or reordered entry is reported at its next issue.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int CNT_W = 3;

  typedef struct packed {
    logic             flush;
    logic [CNT_W-1:0] shift;
    logic [CNT_W-1:0] take;
  } iwStrobe_t;
endpackage

// File: rtl/iw_datapath.sv
module iw_datapath
  import iw_pkg::*;
#(
  parameter int W  = 4,
  parameter int RW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  iwStrobe_t       strb,
  input  logic [W-1:0]    issueVec,
  input  logic [W*RW-1:0] inDst,
  input  logic [W*RW-1:0] inSrcA,
  input  logic [W*RW-1:0] inSrcB,
  input  logic            wbValid,
  input  logic [RW-1:0]   wbReg,
  output logic [W-1:0]    entValid,
  output logic [W-1:0]    hazard,
  output logic [W*RW-1:0] entDst
);
  localparam int NREG = 1 << RW;

  logic [RW-1:0]    dst [W];
  logic [RW-1:0]    srcA[W];
  logic [RW-1:0]    srcB[W];
  logic [RW-1:0]    nDst [W];
  logic [RW-1:0]    nSrcA[W];
  logic [RW-1:0]    nSrcB[W];
  logic [CNT_W-1:0] cnt, nCnt;
  logic [NREG-1:0]  pend, nPend;

  // window view and hazard comparison
  always_comb begin
    for (int i = 0; i < W; i++) begin
      entValid[i] = (i < int'(cnt));
      entDst[i*RW +: RW] = dst[i];
      hazard[i] = pend[srcA[i]] | pend[srcB[i]] | pend[dst[i]];
      for (int j = 0; j < i; j++) begin
        hazard[i] = hazard[i]
                  | (srcA[i] == dst[j]) | (srcB[i] == dst[j])
                  | (dst[i] == dst[j])
                  | (dst[i] == srcA[j]) | (dst[i] == srcB[j]);
      end
    end
  end

  // shift out issued entries, fill from input behind survivors
  always_comb begin
    int sh, tk, rem;
    sh  = int'(strb.shift);
    tk  = int'(strb.take);
    rem = int'(cnt) - sh;
    for (int k = 0; k < W; k++) begin
      nDst[k]  = dst[k];
      nSrcA[k] = srcA[k];
      nSrcB[k] = srcB[k];
      if (k < rem && k + sh < W) begin
        nDst[k]  = dst[k + sh];
        nSrcA[k] = srcA[k + sh];
        nSrcB[k] = srcB[k + sh];
      end else if (k >= rem && k - rem < tk) begin
        nDst[k]  = inDst [(k - rem)*RW +: RW];
        nSrcA[k] = inSrcA[(k - rem)*RW +: RW];
        nSrcB[k] = inSrcB[(k - rem)*RW +: RW];
      end
    end
    nCnt = CNT_W'(rem + tk);
    nPend = pend;
    if (wbValid) nPend[wbReg] = 1'b0;
    for (int i = 0; i < W; i++)
      if (issueVec[i]) nPend[dst[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      cnt  <= '0;
      pend <= '0;
    end else begin
      cnt  <= nCnt;
      pend <= nPend;
    end
    for (int k = 0; k < W; k++) begin
      dst[k]  <= nDst[k];
      srcA[k] <= nSrcA[k];
      srcB[k] <= nSrcB[k];
    end
  end

  // R7: occupancy never exceeds the window
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) <= W);

  // R8: flush leaves an empty window and clean scoreboard
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (cnt == '0) && (pend == '0));

  for (genvar g = 0; g < W; g++) begin : g_chk
    // R5: nothing issues that touches a pending register
    a_r5_issue_not_pending: assert property (@(posedge clk) disable iff (!rstN)
      issueVec[g] |-> !pend[dst[g]] && !pend[srcA[g]] && !pend[srcB[g]]);
    if (g > 0) begin : g_adj
      // R3: no issue reading the destination of the entry just ahead
      a_r3_raw_blocks: assert property (@(posedge clk) disable iff (!rstN)
        issueVec[g] |-> (srcA[g] != dst[g-1]) && (srcB[g] != dst[g-1]));
    end
  end
endmodule

// File: rtl/iw_control.sv
module iw_control
  import iw_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         glideMode,
  input  logic [W-1:0] inValid,
  input  logic [W-1:0] entValid,
  input  logic [W-1:0] hazard,
  output logic [W-1:0] issValid,
  output iwStrobe_t    strb
);
  logic [CNT_W-1:0] nIss, nHeld, offered, freeSlots;

  always_comb begin
    int run;
    issValid[0] = entValid[0] & ~hazard[0] & ~flush;
    for (int i = 1; i < W; i++)
      issValid[i] = issValid[i-1] & entValid[i] & ~hazard[i];
    nIss  = CNT_W'($countones(issValid));
    nHeld = CNT_W'($countones(entValid));
    run = 0;
    for (int k = 0; k < W; k++)
      if (inValid[k] && run == k) run = k + 1;
    offered = CNT_W'(run);
    if (glideMode)            freeSlots = CNT_W'(W) - (nHeld - nIss);
    else if (nHeld == nIss)   freeSlots = CNT_W'(W);
    else                      freeSlots = '0;
    strb.flush = flush;
    strb.shift = nIss;
    strb.take  = flush ? '0 : ((offered < freeSlots) ? offered : freeSlots);
  end

  // R10: legal issue width
  initial a_r10_width_range: assert (W >= 2 && W <= 6);

  // R2: issue vector is a contiguous run from the oldest slot
  a_r2_prefix: assert property (@(posedge clk) disable iff (!rstN)
    ((issValid + 1'b1) & issValid) == '0);

  // R6: fixed mode takes input only when the batch drains completely
  a_r6_fixed_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!glideMode && strb.take != '0) |-> (nIss == nHeld));
endmodule

// File: rtl/issue_window.sv
module issue_window
  import iw_pkg::*;
#(
  parameter int W  = 4,
  parameter int RW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             glideMode,
  input  logic [W-1:0]     inValid,
  input  logic [W*RW-1:0]  inDst,
  input  logic [W*RW-1:0]  inSrcA,
  input  logic [W*RW-1:0]  inSrcB,
  output logic [CNT_W-1:0] inTake,
  input  logic             wbValid,
  input  logic [RW-1:0]    wbReg,
  output logic [W-1:0]     issValid,
  output logic [W*RW-1:0]  issDst
);
  iwStrobe_t    strb;
  logic [W-1:0] entValid, hazard;

  iw_control #(.W(W)) i_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .glideMode(glideMode),
    .inValid(inValid), .entValid(entValid), .hazard(hazard),
    .issValid(issValid), .strb(strb));

  iw_datapath #(.W(W), .RW(RW)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .issueVec(issValid),
    .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .wbValid(wbValid), .wbReg(wbReg),
    .entValid(entValid), .hazard(hazard), .entDst(issDst));

  assign inTake = strb.take;
endmodule

// File: tb/test_issue_window.sv
module test_issue_window;
  localparam int W = 4;
  localparam int RW = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, flush = 0, glideMode = 1, wbValid = 0;
  logic [W-1:0] inValid = '0;
  logic [W*RW-1:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic [RW-1:0] wbReg = '0;
  logic [2:0] inTake;
  logic [W-1:0] issValid;
  logic [W*RW-1:0] issDst;

  int errs = 0, checks = 0;

  // stream of pending instructions (program order)
  logic [RW-1:0] qD[$], qA[$], qB[$];
  // model window and scoreboard
  logic [RW-1:0] mD[W], mA[W], mB[W];
  int mCnt = 0;
  bit [(1<<RW)-1:0] mPend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_window #(.W(W), .RW(RW)) i_issue_window (
    .clk(clk), .rstN(rstN), .flush(flush), .glideMode(glideMode),
    .inValid(inValid), .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .inTake(inTake), .wbValid(wbValid), .wbReg(wbReg),
    .issValid(issValid), .issDst(issDst));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int d, input int a, input int b);
    qD.push_back(RW'(d)); qA.push_back(RW'(a)); qB.push_back(RW'(b));
  endtask

  // one cycle: drive at negedge, check before posedge, advance model
  task automatic step(input int offerN, input bit fl, input bit wv, input int wr,
                      output logic [W-1:0] expIss);
    int n, expTake, held, free, rem;
    bit blk;
    logic [RW-1:0] nD[W], nA[W], nB[W];
    @(negedge clk);
    n = (offerN < qD.size()) ? offerN : qD.size();
    flush = fl; wbValid = wv; wbReg = RW'(wr);
    inValid = '0; inDst = '0; inSrcA = '0; inSrcB = '0;
    for (int k = 0; k < n; k++) begin
      inValid[k] = 1'b1;               // R11 contiguous offer
      inDst[k*RW +: RW] = qD[k]; inSrcA[k*RW +: RW] = qA[k]; inSrcB[k*RW +: RW] = qB[k];
    end
    #1;
    expIss = '0;
    blk = fl;
    for (int i = 0; i < mCnt; i++) begin
      if (mPend[mD[i]] || mPend[mA[i]] || mPend[mB[i]]) blk = 1;
      for (int j = 0; j < i; j++)
        if (mA[i] == mD[j] || mB[i] == mD[j] || mD[i] == mD[j] ||
            mD[i] == mA[j] || mD[i] == mB[j]) blk = 1;
      if (!blk) expIss[i] = 1'b1;
    end
    held = mCnt;
    rem = held - $countones(expIss);
    if (glideMode) free = W - rem;
    else free = (rem == 0) ? W : 0;
    expTake = fl ? 0 : ((n < free) ? n : free);
    chk(issValid == expIss, "R2 R3 R4 R5 R8 issValid", int'(issValid), int'(expIss));
    chk(int'(inTake) == expTake, glideMode ? "R7 R8 inTake" : "R6 R8 inTake",
        int'(inTake), expTake);
    for (int i = 0; i < W; i++)
      if (expIss[i] && issValid[i])
        chk(issDst[i*RW +: RW] == mD[i], "R9 issDst", int'(issDst[i*RW +: RW]), int'(mD[i]));
    // advance model
    if (fl) begin
      mCnt = 0; mPend = '0;
    end else begin
      if (wv) mPend[wr] = 1'b0;
      for (int i = 0; i < W; i++) if (expIss[i]) mPend[mD[i]] = 1'b1;
      for (int k = 0; k < rem; k++) begin
        nD[k] = mD[k + held - rem]; nA[k] = mA[k + held - rem]; nB[k] = mB[k + held - rem];
      end
      for (int k = 0; k < expTake; k++) begin
        nD[rem + k] = qD.pop_front(); nA[rem + k] = qA.pop_front(); nB[rem + k] = qB.pop_front();
      end
      mCnt = rem + expTake;
      for (int k = 0; k < mCnt; k++) begin
        mD[k] = nD[k]; mA[k] = nA[k]; mB[k] = nB[k];
      end
    end
  endtask

  task automatic rndWb(output bit wv, output int wr);
    int pick;
    wv = 0; wr = 0;
    if ($urandom_range(0, 9) < 6 && mPend != 0) begin
      pick = $urandom_range(0, (1<<RW)-1);
      for (int t = 0; t < (1<<RW); t++)
        if (!wv && mPend[(pick + t) % (1<<RW)]) begin wv = 1; wr = (pick + t) % (1<<RW); end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [W-1:0] e;
    bit wv; int wr;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rstN = 1;
    // R1: empty after reset
    @(negedge clk); #1;
    chk(issValid == '0, "R1 reset issValid", int'(issValid), 0);
    // R1/R3: dependent pair, first issues next cycle, second blocked
    push(1, 2, 3); push(4, 1, 5);
    step(2, 0, 0, 0, e);
    chk(int'(inTake) == 2, "R11 take pair", int'(inTake), 2);
    step(0, 0, 0, 0, e);
    chk(issValid == 4'b0001, "R1 R3 raw pair", int'(issValid), 1);
    // R5: second waits on pending r1, writeback releases it
    step(0, 0, 0, 0, e);
    chk(issValid == 4'b0000, "R5 pending blocks", int'(issValid), 0);
    step(0, 0, 1, 1, e);
    step(0, 0, 0, 0, e);
    chk(issValid == 4'b0001, "R5 release after writeback", int'(issValid), 1);
    // R8: flush clears everything
    step(0, 1, 0, 0, e);
    // R4: WAW and WAR pairs
    push(6, 7, 8); push(6, 9, 10); push(11, 12, 13); push(12, 14, 15);
    step(4, 0, 0, 0, e);
    step(0, 0, 0, 0, e);
    chk(issValid == 4'b0001, "R4 waw blocks", int'(issValid), 1);
    step(0, 1, 0, 0, e);
    // R6: fixed mode holds input until batch drains
    glideMode = 0;
    push(1, 2, 3); push(1, 2, 3); push(5, 6, 7);
    step(2, 0, 0, 0, e);
    step(1, 0, 0, 0, e);
    chk(inTake == 3'd0, "R6 fixed holds", int'(inTake), 0);
    step(0, 1, 0, 0, e);
    while (qD.size() > 0) void'(qD.pop_front());
    while (qA.size() > 0) void'(qA.pop_front());
    while (qB.size() > 0) void'(qB.pop_front());
    // random phases: gliding then fixed
    for (int ph = 0; ph < 2; ph++) begin
      glideMode = (ph == 0);
      for (int c = 0; c < 2500; c++) begin
        while (qD.size() < 8)
          push($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15));
        rndWb(wv, wr);
        step($urandom_range(0, W), ($urandom_range(0, 63) == 0), wv, wr, e);
      end
      step(0, 1, 0, 0, e);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule